// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised set of shared interrupt lines and turns them into one request per processor target. Every line is first brought into the local clock domain. It is then qualified by its own sense setting: level or edge, a polarity, and an option to react to both edges. The result is kept as a pending bit. A per-source enable (mask) bit, a pin-enable flag with a pin number, and a one-hot target map decide which target outputs the pending bit reaches.

Software programs the block through a simple word-addressed write port and a combinational read port. Enable bits are changed one source at a time by writing the source index to a set register or a reset register. A single command register, called the wedge here, takes a source index and a direction bit. It can raise a pending bit as a software interrupt or acknowledge a latched edge. The raw pending state of all sources can be read as packed words. Beside each target's request output, the block also reports which pin numbers are active for that target.

Top module: `shic_top`

## Requirements
- R1: After reset every source is level-sensitive, active-high, not dual-edge, disabled (enable bit 0), has its pin flag clear and maps to no target, so `irq_o` and `pin_req_o` are zero. Word 0x000 reads the source-count code N = NUM_SRC/8-1 in bits [7:0].
- R2: A level source (sense bit 0 in word 0x020+w) shows as pending while its synchronised input XOR its polarity bit (word 0x010+w, 1 = active-low) is 1. The pending bit follows an input change on the third rising clock edge after it.
- R3: An edge source (sense bit 1) with dual bit 0 latches pending on a rising input edge when polarity is 0, and on a falling edge when polarity is 1. The opposite edge does nothing. The latched bit stays set after the input returns.
- R4: An edge source whose dual bit (word 0x030+w) is 1 latches pending on both edges, whatever its polarity bit.
- R5: Writing index i in bits [7:0] to word 0x001 sets enable bit i. Writing it to word 0x002 clears enable bit i. An index of NUM_SRC or more changes no enable bit.
- R6: Writing word 0x003 with bit 31 = 1 and index i in bits [7:0] sets pending bit i on that clock edge. On an edge source the bit stays set. On a level source it lasts one cycle before the input-derived value returns. An index out of range does nothing.
- R7: Writing word 0x003 with bit 31 = 0 clears the latched pending bit of an edge source i. The pending bit of a level source is not affected.
- R8: When a wedge clear and a detected edge of the same source meet at one clock edge, the pending bit ends set. A wedge set always leaves the bit set.
- R9: `irq_o[t]` is 1 exactly when some source is pending, enabled, has its pin flag set (bit 31 of word 0x100+s) and has bit t set in its target map (bits [NUM_TGT-1:0] of word 0x200+s).
- R10: `pin_req_o[t*2^PIN_W + p]` is 1 exactly when a source that qualifies for target t under R9 holds pin number p in bits [PIN_W-1:0] of word 0x100+s.
- R11: Polarity, sense, dual, pin and target words read back what was written, limited to implemented bits. Word 0x040+w reads pending and word 0x050+w reads enables, with bit b of word w standing for source 32w+b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Raw shared interrupt lines, asynchronous |
| wr_i | input | 1 | Write strobe, acts on the rising edge |
| addr_i | input | 10 | Word address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | NUM_TGT | One interrupt request per processor target |
| pin_req_o | output | NUM_TGT*2^PIN_W | Active pin numbers per target |

## Verification
An edge seen on a source and a wedge acknowledge written for the same source can land on the same clock edge. If they do, the acknowledge must not swallow the new edge. The bench provokes this by changing the input and then placing the acknowledge write in the cycle where the synchroniser reports the edge. It expects the pending bit to read 1 afterwards. A control case, with the same acknowledge and no edge, expects the bit to read 0.

// File: rtl/shic_pkg.sv
package shic_pkg;

    localparam int unsigned ADDR_W = 10;
    localparam int unsigned DATA_W = 32;

    // single-word command and status registers
    localparam logic [ADDR_W-1:0] A_CFG   = 10'h000;
    localparam logic [ADDR_W-1:0] A_SMASK = 10'h001;
    localparam logic [ADDR_W-1:0] A_RMASK = 10'h002;
    localparam logic [ADDR_W-1:0] A_WEDGE = 10'h003;

    // packed per-source bit arrays, word w at base + w
    localparam logic [ADDR_W-1:0] A_POL  = 10'h010;
    localparam logic [ADDR_W-1:0] A_TRIG = 10'h020;
    localparam logic [ADDR_W-1:0] A_DUAL = 10'h030;
    localparam logic [ADDR_W-1:0] A_PEND = 10'h040;
    localparam logic [ADDR_W-1:0] A_MASK = 10'h050;

    // per-source word arrays, source s at base + s
    localparam logic [ADDR_W-1:0] A_PIN = 10'h100;
    localparam logic [ADDR_W-1:0] A_TGT = 10'h200;

    localparam int unsigned WEDGE_SET_BIT = 31;
    localparam int unsigned PIN_EN_BIT    = 31;

    // state of one source front end
    typedef struct packed {
        logic sync1;
        logic sync2;
        logic prev;
        logic pend;
    } sense_st_t;

endpackage

// File: rtl/shic_sense.sv
module shic_sense
    import shic_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_i,
    input  logic pol_i,
    input  logic edge_i,
    input  logic dual_i,
    input  logic wset_i,
    input  logic wclr_i,
    output logic pend_o
);

    sense_st_t st_d, st_q;
    logic      level_hit;
    logic      rise, fall, edge_hit;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = src_i;
        st_d.sync2 = st_q.sync1;
        st_d.prev  = st_q.sync2;

        level_hit = st_q.sync2 ^ pol_i;
        rise      = st_q.sync2 & ~st_q.prev;
        fall      = ~st_q.sync2 & st_q.prev;
        edge_hit  = dual_i ? (rise | fall) : (pol_i ? fall : rise);

        if (edge_i) begin
            // set over detection over clear
            st_d.pend = wset_i | edge_hit | (st_q.pend & ~wclr_i);
        end else begin
            st_d.pend = wset_i | level_hit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/shic_regs.sv
module shic_regs
    import shic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned NUM_TGT = 4,
    parameter int unsigned PIN_W   = 3
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    input  logic [NUM_SRC-1:0]                pend_i,
    output logic [DATA_W-1:0]                 rdata_o,
    output logic [NUM_SRC-1:0]                pol_o,
    output logic [NUM_SRC-1:0]                edge_o,
    output logic [NUM_SRC-1:0]                dual_o,
    output logic [NUM_SRC-1:0]                mask_o,
    output logic [NUM_SRC-1:0]                pin_en_o,
    output logic [NUM_SRC-1:0][PIN_W-1:0]     pin_o,
    output logic [NUM_SRC-1:0][NUM_TGT-1:0]   tgt_o,
    output logic [NUM_SRC-1:0]                wset_o,
    output logic [NUM_SRC-1:0]                wclr_o
);

    localparam logic [7:0] CNT_CODE = 8'(NUM_SRC / 8 - 1);

    typedef struct packed {
        logic [NUM_SRC-1:0]              pol;
        logic [NUM_SRC-1:0]              edg;
        logic [NUM_SRC-1:0]              dual;
        logic [NUM_SRC-1:0]              mask;
        logic [NUM_SRC-1:0]              pin_en;
        logic [NUM_SRC-1:0][PIN_W-1:0]   pin;
        logic [NUM_SRC-1:0][NUM_TGT-1:0] tgt;
    } cfg_t;

    cfg_t       cfg_d, cfg_q;
    logic [7:0] idx;
    logic       in_bits, in_pin, in_tgt;
    logic [3:0] region;
    logic [3:0] wsel;

    always_comb begin
        idx     = wdata_i[7:0];
        region  = addr_i[7:4];
        wsel    = addr_i[3:0];
        in_bits = (addr_i[9:8] == 2'b00);
        in_pin  = (addr_i[9:8] == A_PIN[9:8]);
        in_tgt  = (addr_i[9:8] == A_TGT[9:8]);
    end

    // next-state of the configuration, plus wedge strobes
    always_comb begin
        cfg_d  = cfg_q;
        wset_o = '0;
        wclr_o = '0;
        if (wr_i) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (addr_i == A_SMASK && idx == 8'(s)) cfg_d.mask[s] = 1'b1;
                if (addr_i == A_RMASK && idx == 8'(s)) cfg_d.mask[s] = 1'b0;
                if (addr_i == A_WEDGE && idx == 8'(s)) begin
                    wset_o[s] = wdata_i[WEDGE_SET_BIT];
                    wclr_o[s] = ~wdata_i[WEDGE_SET_BIT];
                end
                if (in_bits && wsel == 4'(s / 32)) begin
                    if (region == A_POL[7:4])  cfg_d.pol[s]  = wdata_i[5'(s % 32)];
                    if (region == A_TRIG[7:4]) cfg_d.edg[s]  = wdata_i[5'(s % 32)];
                    if (region == A_DUAL[7:4]) cfg_d.dual[s] = wdata_i[5'(s % 32)];
                end
                if (in_pin && addr_i[7:0] == 8'(s)) begin
                    cfg_d.pin_en[s] = wdata_i[PIN_EN_BIT];
                    cfg_d.pin[s]    = wdata_i[PIN_W-1:0];
                end
                if (in_tgt && addr_i[7:0] == 8'(s)) begin
                    cfg_d.tgt[s] = wdata_i[NUM_TGT-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    // read path
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CFG) rdata_o[7:0] = CNT_CODE;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (in_bits && wsel == 4'(s / 32)) begin
                if (region == A_POL[7:4])  rdata_o[5'(s % 32)] = cfg_q.pol[s];
                if (region == A_TRIG[7:4]) rdata_o[5'(s % 32)] = cfg_q.edg[s];
                if (region == A_DUAL[7:4]) rdata_o[5'(s % 32)] = cfg_q.dual[s];
                if (region == A_PEND[7:4]) rdata_o[5'(s % 32)] = pend_i[s];
                if (region == A_MASK[7:4]) rdata_o[5'(s % 32)] = cfg_q.mask[s];
            end
            if (in_pin && addr_i[7:0] == 8'(s)) begin
                rdata_o[PIN_EN_BIT]  = cfg_q.pin_en[s];
                rdata_o[PIN_W-1:0]   = cfg_q.pin[s];
            end
            if (in_tgt && addr_i[7:0] == 8'(s)) begin
                rdata_o[NUM_TGT-1:0] = cfg_q.tgt[s];
            end
        end
    end

    assign pol_o    = cfg_q.pol;
    assign edge_o   = cfg_q.edg;
    assign dual_o   = cfg_q.dual;
    assign mask_o   = cfg_q.mask;
    assign pin_en_o = cfg_q.pin_en;
    assign pin_o    = cfg_q.pin;
    assign tgt_o    = cfg_q.tgt;

endmodule

// File: rtl/shic_route.sv
module shic_route #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned NUM_TGT = 4,
    parameter int unsigned PIN_W   = 3
) (
    input  logic [NUM_SRC-1:0]                  pend_i,
    input  logic [NUM_SRC-1:0]                  mask_i,
    input  logic [NUM_SRC-1:0]                  pin_en_i,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]       pin_i,
    input  logic [NUM_SRC-1:0][NUM_TGT-1:0]     tgt_i,
    output logic [NUM_TGT-1:0]                  irq_o,
    output logic [NUM_TGT*(1<<PIN_W)-1:0]       pin_req_o
);

    localparam int unsigned NUM_PIN = 1 << PIN_W;

    logic [NUM_SRC-1:0]               live;
    logic [NUM_TGT-1:0][NUM_SRC-1:0]  to_tgt;
    logic [NUM_PIN-1:0][NUM_SRC-1:0]  on_pin;

    assign live = pend_i & mask_i & pin_en_i;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar t = 0; t < NUM_TGT; t++) begin : g_tcol
            assign to_tgt[t][s] = live[s] & tgt_i[s][t];
        end
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pcol
            assign on_pin[p][s] = (pin_i[s] == PIN_W'(p));
        end
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        assign irq_o[t] = |to_tgt[t];
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            assign pin_req_o[t*NUM_PIN + p] = |(to_tgt[t] & on_pin[p]);
        end
    end

endmodule

// File: rtl/shic_top.sv
module shic_top
    import shic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned NUM_TGT = 4,
    parameter int unsigned PIN_W   = 3
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [NUM_SRC-1:0]                src_i,
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    output logic [DATA_W-1:0]                 rdata_o,
    output logic [NUM_TGT-1:0]                irq_o,
    output logic [NUM_TGT*(1<<PIN_W)-1:0]     pin_req_o
);

    logic [NUM_SRC-1:0]              pend_w, pol_w, edge_w, dual_w, mask_w, pin_en_w;
    logic [NUM_SRC-1:0]              wset_w, wclr_w;
    logic [NUM_SRC-1:0][PIN_W-1:0]   pin_w;
    logic [NUM_SRC-1:0][NUM_TGT-1:0] tgt_w;

    shic_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_TGT (NUM_TGT),
        .PIN_W   (PIN_W)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .pend_i   (pend_w),
        .rdata_o  (rdata_o),
        .pol_o    (pol_w),
        .edge_o   (edge_w),
        .dual_o   (dual_w),
        .mask_o   (mask_w),
        .pin_en_o (pin_en_w),
        .pin_o    (pin_w),
        .tgt_o    (tgt_w),
        .wset_o   (wset_w),
        .wclr_o   (wclr_w)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_sense
        shic_sense u_sense (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .src_i  (src_i[s]),
            .pol_i  (pol_w[s]),
            .edge_i (edge_w[s]),
            .dual_i (dual_w[s]),
            .wset_i (wset_w[s]),
            .wclr_i (wclr_w[s]),
            .pend_o (pend_w[s])
        );
    end

    shic_route #(
        .NUM_SRC (NUM_SRC),
        .NUM_TGT (NUM_TGT),
        .PIN_W   (PIN_W)
    ) u_route (
        .pend_i    (pend_w),
        .mask_i    (mask_w),
        .pin_en_i  (pin_en_w),
        .pin_i     (pin_w),
        .tgt_i     (tgt_w),
        .irq_o     (irq_o),
        .pin_req_o (pin_req_o)
    );

endmodule

// File: rtl/shic_chk.sv
module shic_chk
    import shic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned NUM_TGT = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                wr_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic                wset_bit_i,
    input logic [7:0]          idx_i,
    input logic [NUM_SRC-1:0]  pend_i,
    input logic [NUM_SRC-1:0]  mask_i,
    input logic [NUM_TGT-1:0]  irq_i
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic             in_rng;
    logic             set_q, smask_q, rmask_q, oor_q;
    logic [IDX_W-1:0] idx_q;

    assign in_rng = ({24'b0, idx_i} < NUM_SRC);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            set_q   <= 1'b0;
            smask_q <= 1'b0;
            rmask_q <= 1'b0;
            oor_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            set_q   <= wr_i && addr_i == A_WEDGE && wset_bit_i && in_rng;
            smask_q <= wr_i && addr_i == A_SMASK && in_rng;
            rmask_q <= wr_i && addr_i == A_RMASK && in_rng;
            oor_q   <= wr_i && (addr_i == A_SMASK || addr_i == A_RMASK) && !in_rng;
            idx_q   <= idx_i[IDX_W-1:0];
        end
    end

    // R6
    wedge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_q |-> pend_i[idx_q]);

    // R5
    smask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smask_q |-> mask_i[idx_q]);

    // R5
    rmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rmask_q |-> !mask_i[idx_q]);

    // R5
    mask_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oor_q |-> $stable(mask_i));

    // R9
    irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_i) |-> (|(pend_i & mask_i)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_i & mask_i) == '0) |-> (irq_i == '0));

endmodule

bind shic_top shic_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_TGT (NUM_TGT)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wset_bit_i (wdata_i[31]),
    .idx_i      (wdata_i[7:0]),
    .pend_i     (pend_w),
    .mask_i     (mask_w),
    .irq_i      (irq_o)
);

// File: tb/shic_top_bench.sv
module shic_top_bench;
    import shic_pkg::*;

    localparam int unsigned NSRC = 16;
    localparam int unsigned NTGT = 4;
    localparam int unsigned PW   = 3;
    localparam int unsigned NPIN = 1 << PW;

    typedef struct packed {
        logic        rd;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 10'h000, 32'h0000_0001, 8'd1},   // R1 count code
        '{1'b1, 10'h050, 32'h0000_0000, 8'd1},   // R1 all disabled
        '{1'b1, 10'h010, 32'h0000_0000, 8'd1},   // R1 active-high
        '{1'b1, 10'h020, 32'h0000_0000, 8'd1},   // R1 level
        '{1'b1, 10'h105, 32'h0000_0000, 8'd1},   // R1 pin flag clear
        '{1'b0, 10'h010, 32'h0000_00F0, 8'd11},
        '{1'b1, 10'h010, 32'h0000_00F0, 8'd11},  // R11 polarity readback
        '{1'b0, 10'h010, 32'h0000_0000, 8'd2},
        '{1'b1, 10'h040, 32'h0000_00F0, 8'd2},   // R2 active-low, input 0
        '{1'b1, 10'h040, 32'h0000_0000, 8'd2},   // R2 back to active-high
        '{1'b0, 10'h020, 32'hFFFF_FFFF, 8'd11},
        '{1'b1, 10'h020, 32'h0000_FFFF, 8'd11},  // R11 sense readback, 16 bits
        '{1'b0, 10'h020, 32'h0000_0000, 8'd11},
        '{1'b0, 10'h030, 32'h0000_0003, 8'd11},
        '{1'b1, 10'h030, 32'h0000_0003, 8'd11},  // R11 dual readback
        '{1'b0, 10'h030, 32'h0000_0000, 8'd11},
        '{1'b0, 10'h001, 32'h0000_0005, 8'd5},
        '{1'b0, 10'h001, 32'h0000_0003, 8'd5},
        '{1'b1, 10'h050, 32'h0000_0028, 8'd5},   // R5 set enables
        '{1'b0, 10'h002, 32'h0000_0005, 8'd5},
        '{1'b1, 10'h050, 32'h0000_0008, 8'd5},   // R5 clear enable
        '{1'b0, 10'h001, 32'h0000_0014, 8'd5},
        '{1'b1, 10'h050, 32'h0000_0008, 8'd5},   // R5 index 20 ignored
        '{1'b0, 10'h101, 32'hFFFF_FFFD, 8'd11},
        '{1'b1, 10'h101, 32'h8000_0005, 8'd11},  // R11 pin word readback
        '{1'b0, 10'h201, 32'h0000_00F9, 8'd11},
        '{1'b1, 10'h201, 32'h0000_0009, 8'd11},  // R11 target word readback
        '{1'b0, 10'h003, 32'h8000_0007, 8'd6},
        '{1'b1, 10'h040, 32'h0000_0080, 8'd6},   // R6 level source set, one cycle
        '{1'b1, 10'h040, 32'h0000_0000, 8'd6}    // R6 level source back to input
    };

    logic                   clk_i = 1'b0;
    logic                   rst_ni = 1'b0;
    logic [NSRC-1:0]        src_i = '0;
    logic                   wr_i = 1'b0;
    logic [9:0]             addr_i = '0;
    logic [31:0]            wdata_i = '0;
    logic [31:0]            rdata_o;
    logic [NTGT-1:0]        irq_o;
    logic [NTGT*NPIN-1:0]   pin_req_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [31:0] v;

    always #10 clk_i = ~clk_i;

    shic_top #(.NUM_SRC(NSRC), .NUM_TGT(NTGT), .PIN_W(PW)) u_shic_top (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (src_i),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .irq_o     (irq_o),
        .pin_req_o (pin_req_o)
    );

    task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", r, got, exp);
        end
    endtask

    task automatic wreg(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk_i);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk_i);
        #1 wr_i = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk_i);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic setsrc(input int k, input logic val);
        @(negedge clk_i);
        src_i[k] = val;
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 pin_req", 32'(pin_req_o), 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk_i);
            wr_i = 1'b0;
            addr_i = VEC[i].addr;
            wdata_i = VEC[i].data;
            if (VEC[i].rd) begin
                #1 chk($sformatf("R%0d table %0d", VEC[i].req, i), rdata_o, VEC[i].data);
            end else begin
                wr_i = 1'b1;
            end
        end
        @(negedge clk_i);
        wr_i = 1'b0;
        wreg(A_RMASK, 32'd3);
        wreg(A_PIN + 10'd1, 32'h0);
        wreg(A_TGT + 10'd1, 32'h0);

        // R2 level latency, active-low source 2
        wreg(A_POL, 32'h4);
        repeat (2) @(posedge clk_i);
        rd(A_PEND, v); chk("R2 active-low idle", v & 32'h4, 32'h4);
        setsrc(2, 1'b1);
        repeat (2) @(posedge clk_i);
        rd(A_PEND, v); chk("R2 before third edge", v & 32'h4, 32'h4);
        rd(A_PEND, v); chk("R2 after third edge", v & 32'h4, 32'h0);
        setsrc(3, 1'b1);
        repeat (3) @(posedge clk_i);
        rd(A_PEND, v); chk("R2 active-high", v & 32'h8, 32'h8);

        // R3 single edge
        wreg(A_TRIG, 32'h30);
        wreg(A_POL, 32'h24);
        setsrc(4, 1'b1);
        repeat (3) @(posedge clk_i);
        rd(A_PEND, v); chk("R3 rising", v & 32'h10, 32'h10);
        setsrc(4, 1'b0);
        repeat (4) @(posedge clk_i);
        rd(A_PEND, v); chk("R3 sticky", v & 32'h10, 32'h10);
        setsrc(5, 1'b1);
        repeat (4) @(posedge clk_i);
        rd(A_PEND, v); chk("R3 wrong edge", v & 32'h20, 32'h0);
        setsrc(5, 1'b0);
        repeat (4) @(posedge clk_i);
        rd(A_PEND, v); chk("R3 falling", v & 32'h20, 32'h20);

        // R7 acknowledge
        wreg(A_WEDGE, 32'd4);
        rd(A_PEND, v); chk("R7 clear edge 4", v & 32'h10, 32'h0);
        wreg(A_WEDGE, 32'd5);
        rd(A_PEND, v); chk("R7 clear edge 5", v & 32'h20, 32'h0);
        wreg(A_WEDGE, 32'd3);
        rd(A_PEND, v); chk("R7 level untouched", v & 32'h8, 32'h8);

        // R4 dual edge, polarity 1 ignored
        wreg(A_TRIG, 32'h70);
        wreg(A_DUAL, 32'h40);
        wreg(A_POL, 32'h64);
        setsrc(6, 1'b1);
        repeat (4) @(posedge clk_i);
        rd(A_PEND, v); chk("R4 rise", v & 32'h40, 32'h40);
        wreg(A_WEDGE, 32'd6);
        rd(A_PEND, v); chk("R7 clear dual", v & 32'h40, 32'h0);
        setsrc(6, 1'b0);
        repeat (4) @(posedge clk_i);
        rd(A_PEND, v); chk("R4 fall", v & 32'h40, 32'h40);
        wreg(A_WEDGE, 32'd6);

        // R6 wedge set on edge source stays
        wreg(A_WEDGE, 32'h8000_0004);
        rd(A_PEND, v); chk("R6 edge set", v & 32'h10, 32'h10);
        repeat (3) @(posedge clk_i);
        rd(A_PEND, v); chk("R6 edge set held", v & 32'h10, 32'h10);
        wreg(A_WEDGE, 32'h8000_0014);
        rd(A_PEND, v); chk("R6 out of range", v & 32'hFFFF_FFF7, 32'h10);
        wreg(A_WEDGE, 32'd4);

        // R8 edge and acknowledge on one clock edge
        setsrc(4, 1'b1);
        repeat (2) @(posedge clk_i);
        @(negedge clk_i);
        wr_i = 1'b1; addr_i = A_WEDGE; wdata_i = 32'd4;
        @(posedge clk_i);
        #1 wr_i = 1'b0;
        rd(A_PEND, v); chk("R8 edge beats clear", v & 32'h10, 32'h10);
        wreg(A_WEDGE, 32'd4);
        rd(A_PEND, v); chk("R8 control clear", v & 32'h10, 32'h0);
        wreg(A_WEDGE, 32'h8000_0004);

        // R9 / R10 routing
        wreg(A_PIN + 10'd4, 32'h8000_0005);
        wreg(A_TGT + 10'd4, 32'h4);
        @(negedge clk_i);
        chk("R9 disabled source", 32'(irq_o), 32'h0);
        wreg(A_SMASK, 32'd4);
        @(negedge clk_i);
        chk("R9 one target", 32'(irq_o), 32'h4);
        chk("R10 pin 5 target 2", 32'(pin_req_o), 32'h0020_0000);
        wreg(A_PIN + 10'd4, 32'h5);
        @(negedge clk_i);
        chk("R9 pin flag off", 32'(irq_o), 32'h0);
        wreg(A_PIN + 10'd4, 32'h8000_0002);
        wreg(A_PIN + 10'd3, 32'h8000_0001);
        wreg(A_TGT + 10'd3, 32'h5);
        wreg(A_SMASK, 32'd3);
        @(negedge clk_i);
        chk("R9 two sources", 32'(irq_o), 32'h5);
        chk("R10 merged pins", 32'(pin_req_o), 32'h0006_0002);
        wreg(A_WEDGE, 32'd4);
        @(negedge clk_i);
        chk("R9 after ack", 32'(irq_o), 32'h5);
        chk("R10 after ack", 32'(pin_req_o), 32'h0002_0002);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule